// File: doc/BRIEF.md
# UART Receive Buffer and Status Flags

This block is the back end of a UART receiver. A bit-recovery front end hands it each finished character as a one-cycle strobe with the character bits and three per-character error indications (noise seen during sampling, bad stop bit, parity mismatch). The block moves the character into a receive data buffer and maintains the flags a CPU polls: buffer full, line idle, overrun, noise, framing error and parity error.

The data width is a parameter (default 8). In nine-bit mode the extra bit above the data MSB is captured into a separate bit-8 register; in eight-bit mode that register keeps its old value. The CPU clears the flags with a status read followed by a data read. An idle-line strobe from the front end sets the idle flag, but once that flag has been cleared it stays clear until another character has been taken into the buffer.

All flags and buffer contents are registered and change on the clock edge after the strobe that causes them.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, the data buffer, the bit-8 register and all six flags read zero.
- R2: A character strobe while the full flag is clear loads the low DATA_W bits of charData into rxData and sets fullFlag on the next edge.
- R3: The noise, framing and parity flags take the values of the error inputs of the character that sets fullFlag, on the same edge, and are never set while fullFlag is clear.
- R4: A character strobe while fullFlag is set, and no clear takes effect in that cycle, sets overrunFlag and leaves rxData, rxBit8 and the three error flags unchanged.
- R5: A dataRead pulse clears fullFlag, overrunFlag, idleFlag and the three error flags only if a statusRead came in an earlier cycle while at least one of full, overrun or idle was set. A dataRead with no such status read changes nothing.
- R6: A character strobe in the same cycle as a clearing dataRead is loaded as a fresh character: fullFlag stays 1, rxData takes the new bits and overrunFlag stays 0.
- R7: With nineBitMode = 1, a loaded character's bit DATA_W (bit 8 at default) goes to rxBit8.
- R8: With nineBitMode = 0, rxBit8 keeps its previous value and the incoming bit DATA_W is ignored.
- R9: After reset and after every loaded character, an idleDetect pulse sets idleFlag on the next edge.
- R10: Once idleFlag has been cleared, idleDetect pulses leave it at 0 until a new character has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nineBitMode | input | 1 | 1 = nine-bit characters, 0 = eight-bit |
| charValid | input | 1 | One-cycle strobe: a completed character is ready |
| charData | input | DATA_W+1 | Character bits; top bit is the ninth bit |
| charNoise | input | 1 | Noise seen on this character |
| charFrame | input | 1 | Stop bit error on this character |
| charParity | input | 1 | Parity error on this character |
| idleDetect | input | 1 | One-cycle strobe: idle line seen |
| statusRead | input | 1 | CPU reads the status flags |
| dataRead | input | 1 | CPU reads the data buffer |
| rxData | output | DATA_W | Receive data buffer |
| rxBit8 | output | 1 | Received ninth bit |
| fullFlag | output | 1 | Buffer holds an unread character |
| idleFlag | output | 1 | Idle line flag |
| overrunFlag | output | 1 | A character was lost to a full buffer |
| noiseFlag | output | 1 | Noise on the buffered character |
| frameFlag | output | 1 | Framing error on the buffered character |
| parityFlag | output | 1 | Parity error on the buffered character |

## Verification
A wrong clear-arming state shows up at the ports as soon as a data read arrives: flags clear when they should have stayed, or stay set after a proper status-then-data sequence. A lost or stuck idle-enable state is seen on the edge after the next idleDetect, as the idle flag setting when it must not, or failing to set after a new character. A full flag that disagrees with the buffer shows on the next character strobe as a spurious or missing overrun, together with changed or unchanged buffer data and error flags.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  typedef struct packed {
    logic loadChar;
    logic setOverrun;
    logic clearFlags;
  } rxStrobes_t;
endpackage

// File: rtl/uart_rx_status_ctrl.sv
module uart_rx_status_ctrl
  import uart_rx_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       charValid,
  input  logic       idleDetect,
  input  logic       statusRead,
  input  logic       dataRead,
  output rxStrobes_t strobes,
  output logic       fullFlag,
  output logic       overrunFlag,
  output logic       idleFlag
);
  logic clearArmed;
  logic idleEnable;
  logic clearNow;

  assign clearNow = dataRead & clearArmed;

  always_comb begin
    strobes.clearFlags = clearNow;
    strobes.loadChar   = charValid & (~fullFlag | clearNow);
    strobes.setOverrun = charValid & fullFlag & ~clearNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clearArmed  <= 1'b0;
      idleEnable  <= 1'b1;
      fullFlag    <= 1'b0;
      overrunFlag <= 1'b0;
      idleFlag    <= 1'b0;
    end else begin
      if (dataRead)
        clearArmed <= 1'b0;
      else if (statusRead && (fullFlag || overrunFlag || idleFlag))
        clearArmed <= 1'b1;

      if (strobes.loadChar)
        fullFlag <= 1'b1;
      else if (clearNow)
        fullFlag <= 1'b0;

      if (strobes.setOverrun)
        overrunFlag <= 1'b1;
      else if (clearNow)
        overrunFlag <= 1'b0;

      if (clearNow)
        idleFlag <= 1'b0;
      else if (idleDetect && idleEnable)
        idleFlag <= 1'b1;

      if (strobes.loadChar)
        idleEnable <= 1'b1;
      else if (clearNow && idleFlag)
        idleEnable <= 1'b0;
    end
  end

  assert_load_sets_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadChar |=> fullFlag);

  assert_overrun_on_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && fullFlag && !dataRead) |=> overrunFlag);

  assert_unarmed_read_inert_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && !clearArmed && !charValid && fullFlag) |=> fullFlag);

  assert_race_no_overrun_R6: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && clearNow) |=> (fullFlag && !overrunFlag));

  assert_idle_stays_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!idleFlag && !idleEnable) |=> !idleFlag);
endmodule

// File: rtl/uart_rx_status_datapath.sv
module uart_rx_status_datapath
  import uart_rx_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic              nineBitMode,
  input  logic [DATA_W:0]   charData,
  input  logic              charNoise,
  input  logic              charFrame,
  input  logic              charParity,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              noiseFlag,
  output logic              frameFlag,
  output logic              parityFlag
);
  localparam int EXTRA_BIT = DATA_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData     <= '0;
      rxBit8     <= 1'b0;
      noiseFlag  <= 1'b0;
      frameFlag  <= 1'b0;
      parityFlag <= 1'b0;
    end else if (strobes.loadChar) begin
      rxData     <= charData[DATA_W-1:0];
      noiseFlag  <= charNoise;
      frameFlag  <= charFrame;
      parityFlag <= charParity;
      if (nineBitMode)
        rxBit8 <= charData[EXTRA_BIT];
    end else if (strobes.clearFlags) begin
      noiseFlag  <= 1'b0;
      frameFlag  <= 1'b0;
      parityFlag <= 1'b0;
    end
  end

  assert_overrun_keeps_buffer_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setOverrun |=> ($stable(rxData) && $stable(rxBit8) && $stable(noiseFlag)
                            && $stable(frameFlag) && $stable(parityFlag)));

  assert_bit8_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !nineBitMode |=> $stable(rxBit8));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nineBitMode,
  input  logic              charValid,
  input  logic [DATA_W:0]   charData,
  input  logic              charNoise,
  input  logic              charFrame,
  input  logic              charParity,
  input  logic              idleDetect,
  input  logic              statusRead,
  input  logic              dataRead,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              fullFlag,
  output logic              idleFlag,
  output logic              overrunFlag,
  output logic              noiseFlag,
  output logic              frameFlag,
  output logic              parityFlag
);
  rxStrobes_t strobes;

  uart_rx_status_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .charValid(charValid), .idleDetect(idleDetect),
    .statusRead(statusRead), .dataRead(dataRead), .strobes(strobes),
    .fullFlag(fullFlag), .overrunFlag(overrunFlag), .idleFlag(idleFlag)
  );

  uart_rx_status_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .nineBitMode(nineBitMode),
    .charData(charData), .charNoise(charNoise), .charFrame(charFrame),
    .charParity(charParity), .rxData(rxData), .rxBit8(rxBit8),
    .noiseFlag(noiseFlag), .frameFlag(frameFlag), .parityFlag(parityFlag)
  );

  assert_errors_need_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (noiseFlag || frameFlag || parityFlag) |-> fullFlag);
endmodule

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              nineBitMode = 1'b0;
  logic              charValid = 1'b0;
  logic [DATA_W:0]   charData = '0;
  logic              charNoise = 1'b0;
  logic              charFrame = 1'b0;
  logic              charParity = 1'b0;
  logic              idleDetect = 1'b0;
  logic              statusRead = 1'b0;
  logic              dataRead = 1'b0;
  logic [DATA_W-1:0] rxData;
  logic              rxBit8, fullFlag, idleFlag, overrunFlag;
  logic              noiseFlag, frameFlag, parityFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_status #(.DATA_W(DATA_W)) i_uart_rx_status (
    .clk(clk), .rstN(rstN), .nineBitMode(nineBitMode), .charValid(charValid),
    .charData(charData), .charNoise(charNoise), .charFrame(charFrame),
    .charParity(charParity), .idleDetect(idleDetect), .statusRead(statusRead),
    .dataRead(dataRead), .rxData(rxData), .rxBit8(rxBit8), .fullFlag(fullFlag),
    .idleFlag(idleFlag), .overrunFlag(overrunFlag), .noiseFlag(noiseFlag),
    .frameFlag(frameFlag), .parityFlag(parityFlag)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic endPulse();
    @(negedge clk);
    charValid = 1'b0; idleDetect = 1'b0; statusRead = 1'b0; dataRead = 1'b0;
  endtask

  task automatic sendChar(input logic [DATA_W:0] d, input logic n, input logic f, input logic p);
    @(negedge clk);
    charValid = 1'b1; charData = d; charNoise = n; charFrame = f; charParity = p;
    endPulse();
  endtask

  task automatic readStatus();
    @(negedge clk); statusRead = 1'b1; endPulse();
  endtask

  task automatic readData();
    @(negedge clk); dataRead = 1'b1; endPulse();
  endtask

  task automatic pulseIdle();
    @(negedge clk); idleDetect = 1'b1; endPulse();
  endtask

  task automatic clearAll();
    readStatus(); readData();
  endtask

  task automatic t_reset();
    check("R1 rxData", rxData, 0);
    check("R1 rxBit8", rxBit8, 0);
    check("R1 flags", {fullFlag, idleFlag, overrunFlag, noiseFlag, frameFlag, parityFlag}, 0);
  endtask

  task automatic t_basic();
    nineBitMode = 1'b0;
    sendChar(9'h0A5, 0, 0, 0);
    check("R2 rxData", rxData, 8'hA5);
    check("R2 fullFlag", fullFlag, 1);
    check("R3 no errors", {noiseFlag, frameFlag, parityFlag}, 0);
    readData();
    check("R5 lone dataRead keeps full", fullFlag, 1);
    clearAll();
    check("R5 cleared full", fullFlag, 0);
  endtask

  task automatic t_errorsOverrun();
    nineBitMode = 1'b0;
    sendChar(9'h13C, 1, 0, 1);
    check("R3 errors", {noiseFlag, frameFlag, parityFlag}, 3'b101);
    check("R8 bit8 ignored", rxBit8, 0);
    sendChar(9'h055, 0, 1, 0);
    check("R4 overrun", overrunFlag, 1);
    check("R4 data kept", rxData, 8'h3C);
    check("R4 errors kept", {noiseFlag, frameFlag, parityFlag}, 3'b101);
    clearAll();
    check("R5 all cleared", {fullFlag, overrunFlag, noiseFlag, frameFlag, parityFlag}, 0);
  endtask

  task automatic t_nineBit();
    nineBitMode = 1'b1;
    sendChar(9'h1C3, 0, 0, 0);
    check("R7 bit8", rxBit8, 1);
    check("R7 data", rxData, 8'hC3);
    clearAll();
    nineBitMode = 1'b0;
    sendChar(9'h022, 0, 0, 0);
    check("R8 bit8 held", rxBit8, 1);
    check("R8 data", rxData, 8'h22);
    clearAll();
  endtask

  task automatic t_clearRace();
    nineBitMode = 1'b0;
    sendChar(9'h011, 0, 0, 0);
    readStatus();
    @(negedge clk);
    dataRead = 1'b1; charValid = 1'b1; charData = 9'h077;
    charNoise = 1'b0; charFrame = 1'b1; charParity = 1'b0;
    endPulse();
    check("R6 data", rxData, 8'h77);
    check("R6 full/overrun", {fullFlag, overrunFlag}, 2'b10);
    check("R6 errors new", {noiseFlag, frameFlag, parityFlag}, 3'b010);
    clearAll();
  endtask

  task automatic t_idle();
    pulseIdle();
    check("R9 idle set", idleFlag, 1);
    clearAll();
    check("R5 idle cleared", idleFlag, 0);
    pulseIdle();
    check("R10 idle stays clear", idleFlag, 0);
    sendChar(9'h005, 0, 0, 0);
    check("R10 no idle on char", idleFlag, 0);
    clearAll();
    pulseIdle();
    check("R9 idle after char", idleFlag, 1);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_errorsOverrun();
    t_nineBit();
    t_clearRace();
    t_idle();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule